// File: doc/BRIEF.md
# Pulse-Interval Write Frame Modulator

This block sends one programming frame to a low-frequency tag by switching the reader field on and off. The field-enable output drives the carrier gate. Each data bit takes a fixed 2 ms slot. The slot opens with a field gap, and the length of that gap encodes the bit. A long gap means a one and a short gap means a zero. The field comes back on for the rest of the slot.

A frame runs in a fixed order:
1. The field stays on for a charging period.
2. The bit slots follow at once, carrying 14 bytes in total: a keyword byte, a password byte, the 64-bit payload, the 16-bit checksum and a two-byte write command.
3. The field then stays on for a programming hold.
4. The field turns off and the block signals completion.

Payload and checksum are captured when the frame starts, so they may change afterwards. All durations are counted in 10 µs ticks. These ticks are prescaled from the system clock using the frequency parameters, so the clock counts for every duration follow from the ratio CLK_HZ/TICK_HZ.

Top module: `pwfm_write_modulator`

## Requirements
- R1: After reset and while idle, `field_en`, `busy` and `done` are all 0.
- R2: A `start` pulse while idle sets `busy` and `field_en` from the next clock. The field then stays on for 5000 ticks of charging before the first bit gap.
- R3: A bit of value 1 is sent as 100 ticks with `field_en` = 0, followed by 100 ticks with `field_en` = 1.
- R4: A bit of value 0 is sent as 30 ticks with `field_en` = 0, followed by 170 ticks with `field_en` = 1.
- R5: The frame has 112 bits made of 14 bytes, in this order:
  - 0xBB
  - 0xEB
  - payload bytes 0 to 7, where byte k is `payload[8k+7:8k]`, starting with k = 0
  - checksum bits [7:0]
  - checksum bits [15:8]
  - 0x00
  - 0x03
- R6: Within every byte, bit 0 is sent first and bit 7 last.
- R7: After the on-time of the last bit, `field_en` stays 1 for another 5000 ticks, then goes to 0.
- R8: `done` is high for exactly one clock. That clock is the first one in which `busy` and `field_en` are 0 after the programming hold.
- R9: A `start` pulse while `busy` is 1 has no effect. The frame in progress continues unchanged and no new frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame request, sampled at the rising clock edge |
| payload | input | 64 | Payload data, captured when the frame starts |
| checksum | input | 16 | Checksum word, captured when the frame starts |
| field_en | output | 1 | Reader field enable: 1 means carrier on |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock pulse at the end of the frame |

## Verification
The bench runs with one clock per tick. With that setting, `busy` and `field_en` rise in the first cycle after the edge that samples `start`, and each phase then lasts exactly its tick count in cycles. The bench samples on the falling edge and measures every run of constant `field_en` level:
- the first high run must last 5000 cycles;
- each low run decodes one bit, and its length and the following high run are checked against the value computed in the bench;
- the final high run must last 5000 cycles longer than a normal slot's on-time.

`done` is checked in the same sample where the field first drops after the hold, and again one cycle later. For the ignored-request case, a `start` pulse is injected during a bit gap. The whole frame is then measured to confirm that its timing is unchanged.

// File: rtl/pwfm_pkg.sv
// Shared types and frame constants for the pulse-interval write modulator.
// Assumes a frame of fixed byte count; bit order within the frame is
// defined by the concatenation in pwfm_frame_bits.
package pwfm_pkg;
    localparam int FRAME_BYTES = 14;
    localparam int FRAME_BITS  = FRAME_BYTES * 8;
    localparam int IDX_W       = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHARGE = 3'd1,
        ST_GAP    = 3'd2,
        ST_FILL   = 3'd3,
        ST_HOLD   = 3'd4
    } pwfm_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/pwfm_tick_gen.sv
// Tick prescaler: emits a one-clock tick every DIV clocks while run is high.
// Assumes DIV >= 1; the counter restarts from zero whenever run is low so the
// first tick of a frame comes DIV clocks after the frame starts.
module pwfm_tick_gen #(
    parameter int DIV = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count clocks between ticks; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    AST_TICK_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R2
    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R2
endmodule

// File: rtl/pwfm_phase_timer.sv
// Phase timer: counts ticks within the current phase and flags the tick on
// which the phase of length len ends. Assumes len >= 1 and that len only
// changes on the clock where expire is high or while clear is high.
module pwfm_phase_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = tick && (cnt == len - 1'b1);

    // Advance once per tick, wrap to zero when the phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (expire) cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt < len)); // R3
endmodule

// File: rtl/pwfm_frame_bits.sv
// Frame store: captures payload and checksum on load and presents the bit at
// position idx of the fixed frame. Bit 0 is bit 0 of the keyword byte, so the
// frame is sent byte by byte, least significant bit first.
module pwfm_frame_bits
    import pwfm_pkg::*;
#(
    parameter logic [7:0]  KEYWORD  = 8'hBB,
    parameter logic [7:0]  PASSWORD = 8'hEB,
    parameter logic [15:0] WRITE_CMD = 16'h0300
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [63:0]      payload,
    input  logic [15:0]      checksum,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_out
);
    logic [FRAME_BITS-1:0] frame_q;

    // Capture the whole frame image at the start of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= '0;
        else if (load) frame_q <= {WRITE_CMD, checksum, payload, PASSWORD, KEYWORD};
    end

    assign bit_out = frame_q[idx];

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(FRAME_BITS)); // R5
endmodule

// File: rtl/pwfm_write_modulator.sv
// Top of the write frame modulator. Sequences charge, 112 bit slots and the
// programming hold, and drives the field enable. Assumes CLK_HZ is an integer
// multiple of TICK_HZ; start is ignored unless the block is idle.
module pwfm_write_modulator
    import pwfm_pkg::*;
#(
    parameter int CLK_HZ         = 48_000_000,
    parameter int TICK_HZ        = 100_000,
    parameter int ONE_GAP_TICKS  = 100,
    parameter int ZERO_GAP_TICKS = 30,
    parameter int SLOT_TICKS     = 200,
    parameter int CHARGE_TICKS   = 5000,
    parameter int HOLD_TICKS     = 5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] payload,
    input  logic [15:0] checksum,
    output logic        field_en,
    output logic        busy,
    output logic        done
);
    localparam int DIV     = CLK_HZ / TICK_HZ;
    localparam int LONGEST = max3(CHARGE_TICKS, HOLD_TICKS, SLOT_TICKS);
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

    pwfm_state_e      state;
    logic [IDX_W-1:0] bit_idx;
    logic             cur_bit;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] phase_len;
    logic             accept;

    assign accept   = (state == ST_IDLE) && start;
    assign busy     = (state != ST_IDLE);
    assign field_en = (state == ST_CHARGE) || (state == ST_FILL) || (state == ST_HOLD);

    pwfm_tick_gen #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    pwfm_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(!busy), .tick(tick),
        .len(phase_len), .expire(expire)
    );

    pwfm_frame_bits u_frame (
        .clk(clk), .rst_n(rst_n), .load(accept), .payload(payload),
        .checksum(checksum), .idx(bit_idx), .bit_out(cur_bit)
    );

    // Pick the tick length of the current phase from state and bit value.
    always_comb begin
        case (state)
            ST_CHARGE: phase_len = CNT_W'(CHARGE_TICKS);
            ST_GAP:    phase_len = cur_bit ? CNT_W'(ONE_GAP_TICKS) : CNT_W'(ZERO_GAP_TICKS);
            ST_FILL:   phase_len = cur_bit ? CNT_W'(SLOT_TICKS - ONE_GAP_TICKS)
                                           : CNT_W'(SLOT_TICKS - ZERO_GAP_TICKS);
            ST_HOLD:   phase_len = CNT_W'(HOLD_TICKS);
            default:   phase_len = CNT_W'(1);
        endcase
    end

    // Frame sequencer: advance phase and bit index at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_CHARGE;
                    bit_idx <= '0;
                end
                ST_CHARGE: if (expire) state <= ST_GAP;
                ST_GAP:    if (expire) state <= ST_FILL;
                ST_FILL: if (expire) begin
                    if (bit_idx == LAST_BIT) state <= ST_HOLD;
                    else begin
                        bit_idx <= bit_idx + 1'b1;
                        state   <= ST_GAP;
                    end
                end
                ST_HOLD: if (expire) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !field_en)); // R8
    AST_END_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state != ST_HOLD) |=> busy); // R9
    AST_IDX_HOLDS_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> $stable(bit_idx)); // R6
    AST_IDLE_FIELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !field_en); // R1
endmodule

// File: tb/pwfm_write_modulator_tb.sv
// Self-checking bench: one clock per tick, measures field run lengths.
module pwfm_write_modulator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] payload = '0;
    logic [15:0] checksum = '0;
    logic        field_en, busy, done;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwfm_write_modulator #(.CLK_HZ(100_000), .TICK_HZ(100_000)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .payload(payload),
        .checksum(checksum), .field_en(field_en), .busy(busy), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected frame bit i from byte order and LSB-first rule.
    function automatic logic exp_bit(input logic [63:0] pl, input logic [15:0] ck, input int i);
        int  b;
        logic [7:0] byt;
        b = i / 8;
        if (b == 0)       byt = 8'hBB;
        else if (b == 1)  byt = 8'hEB;
        else if (b < 10)  byt = pl[(b-2)*8 +: 8];
        else if (b == 10) byt = ck[7:0];
        else if (b == 11) byt = ck[15:8];
        else if (b == 12) byt = 8'h00;
        else              byt = 8'h03;
        return byt[i % 8];
    endfunction

    task automatic run_frame(input logic [63:0] pl, input logic [15:0] ck, input bit poke);
        int n;
        int lo;
        int hi;
        logic eb;
        @(negedge clk);
        payload = pl; checksum = ck; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        payload = ~pl; checksum = ~ck;   // capture must have happened already
        check("R2 busy after start", busy, 1);
        n = 0;
        while (field_en) begin n++; @(negedge clk); end
        check("R2 charge length", n, 5000);
        for (int b = 0; b < 112; b++) begin
            eb = exp_bit(pl, ck, b);
            lo = 0;
            while (!field_en) begin
                lo++;
                start = (poke && b == 40 && lo == 2);
                @(negedge clk);
                start = 1'b0;
                if (poke && b == 40 && lo == 2) check("R9 busy kept after start", busy, 1);
            end
            hi = 0;
            while (field_en) begin hi++; @(negedge clk); end
            check(eb ? "R3 one gap" : "R4 zero gap", lo, eb ? 100 : 30);
            check(poke ? "R9 R5 R6 bit value" : "R5 R6 bit value", (lo == 100) ? 1 : 0, int'(eb));
            if (b == 111) check("R7 last on-time plus hold", hi, SLOT - lo + 5000);
            else          check(eb ? "R3 one fill" : "R4 zero fill", hi, SLOT - lo);
        end
        check("R8 done at frame end", done, 1);
        check("R8 busy low at end", busy, 0);
        @(negedge clk);
        check("R8 done one clock", done, 0);
        check("R7 field off after hold", field_en, 0);
    endtask

    initial begin
        int seed_dummy;
        logic [63:0] rp;
        logic [15:0] rc;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check("R1 field idle in reset", field_en, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 field idle", field_en, 0);
        check("R1 busy idle", busy, 0);
        check("R1 done idle", done, 0);
        run_frame(64'h0, 16'h0, 1'b0);
        rp = {$urandom, $urandom};
        rc = 16'($urandom);
        run_frame(rp, rc, 1'b1);
        run_frame(64'hFFFF_FFFF_FFFF_FFFF, 16'hA55A, 1'b0);
        repeat (20) @(negedge clk);
        check("R9 no second frame", busy, 0);
        check("R1 field off after frames", field_en, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule